// File: doc/BRIEF.md
# Receive Queue with Status and Interrupt Logic

This block holds words that a synchronous serial receiver delivers and gives them back, oldest first, to a CPU or a DMA engine. It also produces the status that software and the DMA controller need. A four-bit level field reports the number of stored words minus one. A not-empty flag tells an empty queue from a full one. A sticky overrun flag records words that were lost. A threshold comparison asks for service. A sticky idle-timeout flag reports that a partial block has been sitting unread.

The status drives one interrupt line and one DMA request line. Simple strobes stand in for register writes: `ovr_clr` and `tmo_clr` are write-one-to-clear pulses. The configuration fields are plain inputs. Shifting, clocking, framing, the transmit side and bus decoding are not part of this block.

Top module: `rx_fifo_stat`

## Requirements
- R1: The queue holds DEPTH (16) words and returns them oldest first. While `not_empty` is 1, `pop_data` shows the oldest word. A pop on an empty queue has no effect.
- R2: `level` equals the stored count minus one, modulo 16. It reads 4'hF both when the queue is empty and when it holds 16 words. `not_empty` is 1 exactly when the count is non-zero.
- R3: A `push_valid` while the queue holds 16 words discards that word and sets `ovr_flag` on the next clock. This repeats for every such push until a slot frees up.
- R4: While `ovr_flag` is 1, `irq` is 1 whatever the enables are. `ovr_flag` never drives `dma_req`. An `ovr_clr` pulse clears it.
- R5: `svc_flag` is 1 when `port_en` is 1 and the count is at least `trig_sel`+1, so `trig_sel`=0 means 1 and `trig_sel`=15 means 16. It drops by itself once pops take the count below that threshold.
- R6: While `port_en` is 0, `svc_flag` reads 0.
- R7: `svc_flag` drives `irq` only when `svc_irq_en`=1 and `svc_dma_en`=0. It drives `dma_req` only when `svc_dma_en`=1 and `svc_irq_en`=0. With both enables set, it drives neither line.
- R8: With `idle_limit`=N≠0 and a non-empty queue, `tmo_flag` sets on the Nth consecutive clock that has no push and no accepted pop. It sets once for each idle period. N=0 disables the timeout. A `tmo_clr` pulse clears the flag.
- R9: `tmo_flag` drives `irq` only when `tmo_irq_en`=1.
- R10: The idle count restarts on any `push_valid`, including a discarded one, and on any accepted pop. It is held at zero while the queue is empty.
- R11: If a clear pulse and a set event for the same sticky flag fall in the same cycle, the flag ends up set.
- R12: An accepted push together with an accepted pop leaves the count unchanged. A push while the queue holds 16 words is discarded even when a pop happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; gates the service request |
| push_valid | input | 1 | Receiver delivers a word this cycle |
| push_data | input | DATA_W | Received word |
| pop | input | 1 | Reader takes the oldest word |
| pop_data | output | DATA_W | Oldest stored word |
| trig_sel | input | 4 | Service threshold minus one |
| idle_limit | input | TO_W | Idle cycles before timeout; 0 disables |
| svc_irq_en | input | 1 | Service request to interrupt enable |
| svc_dma_en | input | 1 | Service request to DMA enable |
| tmo_irq_en | input | 1 | Timeout to interrupt enable |
| ovr_clr | input | 1 | Write-one-to-clear pulse for overrun |
| tmo_clr | input | 1 | Write-one-to-clear pulse for timeout |
| level | output | 4 | Count minus one, modulo 16 |
| not_empty | output | 1 | Queue holds at least one word |
| ovr_flag | output | 1 | Sticky overrun |
| svc_flag | output | 1 | Threshold service request |
| tmo_flag | output | 1 | Sticky idle timeout |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA service request |

## Verification
Two pairs of events can fall in the same cycle here. A clear pulse can coincide with the event that sets its flag again: a push into a full queue, or the final idle cycle. A push and a pop can also arrive together, both in the middle of the range and with the queue full. Directed phases hold `ovr_clr` high while pushing into a full queue and hold `tmo_clr` high across the cycle in which the idle count expires. They also push and pop at once at 16 words. A long random phase then creates many more such collisions. On every clock a queue-based reference model predicts the level, the data, each flag and both request lines, and the bench compares them.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  localparam int unsigned TRIG_W = 4;
  localparam int unsigned LVL_W  = 4;

  // Trigger field encodes thresholds 1..16 as value plus one.
  function automatic logic [LVL_W:0] trig_to_thresh(input logic [TRIG_W-1:0] sel);
    return {1'b0, sel} + (LVL_W+1)'(1);
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_req,
  input  logic [DATA_W-1:0]        push_data,
  input  logic                     pop_req,
  output logic [DATA_W-1:0]        head_data,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     push_acc,
  output logic                     pop_acc,
  output logic                     is_full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              is_empty;

  always_comb begin
    is_full  = (cnt_q == CNT_W'(DEPTH));
    is_empty = (cnt_q == '0);
    push_acc = push_req & ~is_full;
    pop_acc  = pop_req & ~is_empty;
    wr_d     = wr_q + PTR_W'(push_acc);
    rd_d     = rd_q + PTR_W'(pop_acc);
    cnt_d    = cnt_q + CNT_W'(push_acc) - CNT_W'(pop_acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_acc) mem_q[wr_q] <= push_data;
  end

  assign head_data = mem_q[rd_q];
  assign count     = cnt_q;
endmodule

// File: rtl/rxf_idle_timer.sv
module rxf_idle_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            activity,
  input  logic            occupied,
  input  logic [TO_W-1:0] limit,
  output logic            expire
);
  logic [TO_W-1:0] cnt_q, cnt_d;

  // Saturates at the limit so one idle period fires once.
  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (activity || !occupied) begin
      cnt_d = '0;
    end else if ((limit != '0) && (cnt_q < limit)) begin
      cnt_d  = cnt_q + TO_W'(1);
      expire = (cnt_d == limit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rxf_sticky.sv
module rxf_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);
  logic flag_q, flag_d;

  // A set event outranks a clear in the same cycle.
  always_comb flag_d = set_evt | (flag_q & ~clr_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/rx_fifo_stat.sv
module rx_fifo_stat
  import rx_fifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int TO_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  input  logic [3:0]        trig_sel,
  input  logic [TO_W-1:0]   idle_limit,
  input  logic              svc_irq_en,
  input  logic              svc_dma_en,
  input  logic              tmo_irq_en,
  input  logic              ovr_clr,
  input  logic              tmo_clr,
  output logic [3:0]        level,
  output logic              not_empty,
  output logic              ovr_flag,
  output logic              svc_flag,
  output logic              tmo_flag,
  output logic              irq,
  output logic              dma_req
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic [CNT_W-1:0] count;
  logic             push_acc, pop_acc, is_full;
  logic             tmo_fire;
  logic             svc_to_irq, svc_to_dma;

  rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (push_valid),
    .push_data (push_data),
    .pop_req   (pop),
    .head_data (pop_data),
    .count     (count),
    .push_acc  (push_acc),
    .pop_acc   (pop_acc),
    .is_full   (is_full)
  );

  rxf_idle_timer #(.TO_W(TO_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .activity (push_valid | pop_acc),
    .occupied (not_empty),
    .limit    (idle_limit),
    .expire   (tmo_fire)
  );

  rxf_sticky ovr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (push_valid & is_full),
    .clr_evt (ovr_clr),
    .flag    (ovr_flag)
  );

  rxf_sticky tmo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (tmo_fire),
    .clr_evt (tmo_clr),
    .flag    (tmo_flag)
  );

  always_comb begin
    level      = LVL_W'(count - CNT_W'(1));
    not_empty  = (count != '0);
    svc_flag   = port_en & (CNT_W'(count) >= CNT_W'(trig_to_thresh(trig_sel)));
    svc_to_irq = svc_flag & svc_irq_en & ~svc_dma_en;
    svc_to_dma = svc_flag & svc_dma_en & ~svc_irq_en;
    irq        = ovr_flag | svc_to_irq | (tmo_flag & tmo_irq_en);
    dma_req    = svc_to_dma;
  end
endmodule

// File: rtl/rx_fifo_stat_chk.sv
module rx_fifo_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       port_en,
  input logic       push_valid,
  input logic       pop,
  input logic       svc_irq_en,
  input logic       svc_dma_en,
  input logic       tmo_irq_en,
  input logic       ovr_clr,
  input logic [3:0] level,
  input logic       not_empty,
  input logic       ovr_flag,
  input logic       svc_flag,
  input logic       tmo_flag,
  input logic       irq,
  input logic       dma_req
);
  logic at_full;
  assign at_full = not_empty && (level == 4'hF);

  a_r2_empty_alias: assert property (@(posedge clk) disable iff (!rst_n)
    !not_empty |-> level == 4'hF);

  a_r3_ovr_on_full_push: assert property (@(posedge clk) disable iff (!rst_n)
    (at_full && push_valid) |=> ovr_flag);

  a_r4_ovr_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag |-> irq);

  a_r4_dma_only_svc: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> svc_flag);

  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> !svc_flag);

  a_r7_both_en_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_irq_en && svc_dma_en && !ovr_flag && !(tmo_flag && tmo_irq_en)) |-> (!irq && !dma_req));

  a_r11_ovr_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (at_full && push_valid && ovr_clr) |=> ovr_flag);

  a_r12_pushpop_level: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && pop && not_empty && !at_full) |=> $stable(level));
endmodule

bind rx_fifo_stat rx_fifo_stat_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .port_en    (port_en),
  .push_valid (push_valid),
  .pop        (pop),
  .svc_irq_en (svc_irq_en),
  .svc_dma_en (svc_dma_en),
  .tmo_irq_en (tmo_irq_en),
  .ovr_clr    (ovr_clr),
  .level      (level),
  .not_empty  (not_empty),
  .ovr_flag   (ovr_flag),
  .svc_flag   (svc_flag),
  .tmo_flag   (tmo_flag),
  .irq        (irq),
  .dma_req    (dma_req)
);

// File: tb/rx_fifo_stat_tb_top.sv
`timescale 1ns/1ps
module rx_fifo_stat_tb_top;
  localparam int DATA_W = 16;
  localparam int TO_W   = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic port_en, push_valid, pop, svc_irq_en, svc_dma_en, tmo_irq_en, ovr_clr, tmo_clr;
  logic [DATA_W-1:0] push_data, pop_data;
  logic [3:0] trig_sel, level;
  logic [TO_W-1:0] idle_limit;
  logic not_empty, ovr_flag, svc_flag, tmo_flag, irq, dma_req;

  always #4 clk = ~clk;

  rx_fifo_stat #(.DATA_W(DATA_W), .DEPTH(16), .TO_W(TO_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .push_valid(push_valid),
    .push_data(push_data), .pop(pop), .pop_data(pop_data), .trig_sel(trig_sel),
    .idle_limit(idle_limit), .svc_irq_en(svc_irq_en), .svc_dma_en(svc_dma_en),
    .tmo_irq_en(tmo_irq_en), .ovr_clr(ovr_clr), .tmo_clr(tmo_clr), .level(level),
    .not_empty(not_empty), .ovr_flag(ovr_flag), .svc_flag(svc_flag),
    .tmo_flag(tmo_flag), .irq(irq), .dma_req(dma_req)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [DATA_W-1:0] mq[$];
  bit m_ovr = 0, m_tmo = 0;
  int m_idle = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int n = mq.size();
    bit e_svc = port_en && (n >= int'(trig_sel) + 1);
    bit e_irq = m_ovr || (e_svc && svc_irq_en && !svc_dma_en) || (m_tmo && tmo_irq_en);
    bit e_dma = e_svc && svc_dma_en && !svc_irq_en;
    chk("R2", "level", level, (n + 15) % 16);
    chk("R2", "not_empty", not_empty, n > 0);
    if (n > 0) chk("R1", "pop_data", pop_data, mq[0]);
    chk("R3", "ovr_flag", ovr_flag, m_ovr);
    chk("R5", "svc_flag", svc_flag, e_svc);
    chk("R8", "tmo_flag", tmo_flag, m_tmo);
    chk("R4_R7_R9", "irq", irq, e_irq);
    chk("R7", "dma_req", dma_req, e_dma);
  endtask

  task automatic model_edge();
    bit full = (mq.size() == 16);
    bit pop_ok = pop && (mq.size() > 0);
    bit tset = 0;
    bit oset = push_valid && full;   // R12: pop does not rescue a full push
    if (push_valid || pop_ok || mq.size() == 0) m_idle = 0;   // R10
    else if (idle_limit != 0 && m_idle < int'(idle_limit)) begin
      m_idle++;
      if (m_idle == int'(idle_limit)) tset = 1;
    end
    if (pop_ok) void'(mq.pop_front());
    if (push_valid && !full) mq.push_back(push_data);
    m_ovr = oset || (m_ovr && !ovr_clr);   // R11
    m_tmo = tset || (m_tmo && !tmo_clr);
  endtask

  task automatic step(bit pv, logic [DATA_W-1:0] pd, bit pp, bit oc, bit tc);
    push_valid = pv; push_data = pd; pop = pp; ovr_clr = oc; tmo_clr = tc;
    #1;
    compare_all();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    port_en = 1; push_valid = 0; push_data = '0; pop = 0; ovr_clr = 0; tmo_clr = 0;
    trig_sel = 4'd7; idle_limit = 16'd6;
    svc_irq_en = 1; svc_dma_en = 0; tmo_irq_en = 1;
    repeat (3) @(negedge clk);
    #1;
    compare_all();   // reset state, R2
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R5: fill past full
    for (int i = 0; i < 20; i++) step(1, 16'hA000 + 16'(i), 0, 0, 0);
    step(0, 0, 0, 1, 0);                              // R4 clear
    step(1, 16'hBEEF, 0, 1, 0);                       // R11 set wins
    step(1, 16'hC0DE, 1, 0, 0);                       // R12 full push+pop
    step(0, 0, 0, 1, 0);
    for (int i = 0; i < 20; i++) step(0, 0, 1, 0, 0); // drain, pops on empty R1
    // R12 mid-range push+pop
    for (int i = 0; i < 5; i++) step(1, 16'h1100 + 16'(i), 0, 0, 0);
    for (int i = 0; i < 6; i++) step(1, 16'h2200 + 16'(i), 1, 0, 0);

    // R8 R9 R10 timeout with DMA path
    svc_irq_en = 0; svc_dma_en = 1; trig_sel = 4'd2;
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0);  // no refire
    step(0, 0, 1, 0, 0);                               // restart
    for (int i = 0; i < 9; i++) step(0, 0, 0, 0, 1);  // R11 clear held across fire
    step(0, 0, 0, 0, 1);
    tmo_irq_en = 0;
    step(1, 16'h3300, 0, 0, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0);

    // R6 R7
    port_en = 0;
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1);
    port_en = 1; svc_irq_en = 1; svc_dma_en = 1;
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0);
    idle_limit = 0;
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 0);

    // random collisions
    for (int i = 0; i < 4000; i++) begin
      if (i % 200 == 0) begin
        port_en    = ($urandom_range(0, 7) != 0);
        trig_sel   = 4'($urandom_range(0, 15));
        idle_limit = 16'($urandom_range(0, 8));
        svc_irq_en = 1'($urandom_range(0, 1));
        svc_dma_en = 1'($urandom_range(0, 1));
        tmo_irq_en = 1'($urandom_range(0, 1));
      end
      step(($urandom_range(0, 9) < 4) ^ (i % 400 < 200), 16'($urandom),
           $urandom_range(0, 9) < 4, $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule